// File: doc/BRIEF.md
# PCI Function Configuration State Controller

This block keeps the lifecycle state of a small table of hot-pluggable PCI functions. Each occupied slot holds a 32-bit function identifier, one of six lifecycle states (reserved, standby, disabled, enabled, blocked, error) and a few per-function flags: interrupt summary registered, address translation enabled, function-handle enable and unplug pending. Commands arrive as a one-cycle valid pulse with an opcode and an identifier. The identifier is matched against all slots in parallel.

Every command gets a registered response one cycle later. The response carries a result code, the slot and the state the addressed function is left in. In the same cycle the block may raise strobes that other logic acts on: tear down interrupt routing, tear down address translation, perform an unplug, or signal a deconfigure-request event to the host.

Configure and deconfigure do not give symmetric results. An unplug asked for while a function is in use is only latched, and it completes when that function is next deconfigured. An attach opcode installs a function in the lowest free slot. A set-state opcode lets neighbouring logic move a function into enabled, blocked or error. A query opcode reads a function back without changing it.

Top module: `fcfg_ctrl`

## Requirements
- R1: A command whose identifier matches no occupied slot (other than attach) returns code 4 (unknown identifier) and leaves every slot unchanged. The result codes are 1 normal, 2 no action, 3 reserved, 4 unknown identifier, 5 table full and 6 identifier in use. The state codes are 0 reserved, 1 standby, 2 disabled, 3 enabled, 4 blocked and 5 error. The opcodes are 0 attach, 1 configure, 2 deconfigure, 3 unplug request, 4 function reset, 5 set state and 6 query.
- R2: Configure on a reserved function returns code 3 and leaves the state reserved.
- R3: Configure on a standby function moves it to disabled with code 1. Configure in any other state returns code 2 with no change.
- R4: Deconfigure on a reserved function returns code 3. Deconfigure on a standby function returns code 2. In both cases the state is unchanged.
- R5: Deconfigure in disabled, enabled, blocked or error moves the function to standby with code 1. It pulses teardown_irq only if an interrupt summary was registered, and teardown_xlat only if translation was enabled. Both flags and the handle enable are cleared afterwards.
- R6: A deconfigure that completes on a function with an unplug pending also pulses unplug_fire and frees the slot.
- R7: An unplug request on a standby or reserved function pulses unplug_fire at once and frees the slot. In any other state it latches the pending flag and pulses deconf_req_evt instead. A repeated request pulses the event again. Both cases return code 1.
- R8: Function reset leaves a reserved function untouched and a standby function in standby. Any other state goes to disabled with the handle enable cleared. In every state except reserved, the teardown strobes follow the R5 flag rule. The code is 1.
- R9: Attach installs the identifier in the lowest free slot, with the state taken from cmd_state and all flags clear, and returns code 1 and that slot. An identifier already present returns code 6. A full table returns code 5.
- R10: Set state writes cmd_state, takes the interrupt-registered flag from cmd_flags bit 0 and the translation flag from cmd_flags bit 1, and sets the handle enable exactly when the new state is enabled. Query changes nothing. Both return code 1 and report state and handle enable.
- R11: rsp_valid and all strobes appear exactly one cycle after the cmd_valid pulse and last one cycle. No strobe appears without a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_fid | input | 32 | Function identifier addressed |
| cmd_state | input | 3 | State for attach and set state |
| cmd_flags | input | 2 | Bit 0 interrupt registered, bit 1 translation enabled (set state) |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 4 | Result code |
| rsp_state | output | 3 | State of the addressed function after the command |
| rsp_fh_en | output | 1 | Handle enable of the addressed function after the command |
| rsp_slot | output | 3 | Slot that was addressed or allocated |
| teardown_irq | output | 1 | Interrupt teardown request pulse |
| teardown_xlat | output | 1 | Translation teardown request pulse |
| unplug_fire | output | 1 | Perform-unplug pulse |
| deconf_req_evt | output | 1 | Deconfigure-request event pulse |

## Verification
A wrong state held in a slot cannot be seen directly. It shows up on the next command to that identifier, which returns the wrong code or state, or raises a teardown or unplug strobe in the wrong place. A stale pending flag, for example, stays hidden until a later deconfigure either fires or withholds unplug_fire. The bench therefore follows each state-changing command with a query or a second command, one response cycle later. That keeps every corruption within two commands of the stimulus that caused it.

// File: rtl/fcfg_pkg.sv
package fcfg_pkg;

    typedef enum logic [2:0] {
        ST_RESERVED = 3'd0,
        ST_STANDBY  = 3'd1,
        ST_DISABLED = 3'd2,
        ST_ENABLED  = 3'd3,
        ST_BLOCKED  = 3'd4,
        ST_ERROR    = 3'd5
    } fn_state_e;

    typedef enum logic [2:0] {
        OP_ATTACH   = 3'd0,
        OP_CONFIG   = 3'd1,
        OP_DECONFIG = 3'd2,
        OP_UNPLUG   = 3'd3,
        OP_FNRESET  = 3'd4,
        OP_SETSTATE = 3'd5,
        OP_QUERY    = 3'd6
    } cmd_op_e;

    typedef enum logic [3:0] {
        RC_NONE      = 4'd0,
        RC_NORMAL    = 4'd1,
        RC_NO_ACTION = 4'd2,
        RC_RESERVED  = 4'd3,
        RC_UNKNOWN   = 4'd4,
        RC_FULL      = 4'd5,
        RC_IN_USE    = 4'd6
    } rsp_code_e;

    typedef struct packed {
        logic [2:0] state;
        logic       unplug_pend;
        logic       irq_reg;
        logic       xlat_en;
        logic       fh_en;
    } fn_entry_t;

endpackage

// File: rtl/fcfg_lookup.sv
module fcfg_lookup #(
    parameter int NSLOT = 8,
    parameter int FIDW  = 32,
    localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [FIDW-1:0]             key,
    input  logic [NSLOT-1:0]            used,
    input  logic [NSLOT-1:0][FIDW-1:0]  ids,
    output logic [NSLOT-1:0]            match,
    output logic                        hit,
    output logic [IDXW-1:0]             hit_idx,
    output logic                        free_any,
    output logic [IDXW-1:0]             free_idx
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign match[g] = used[g] && (ids[g] == key);
    end

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDXW'(i);
            end
            if (!used[i]) begin
                free_any = 1'b1;
                free_idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/fcfg_decide.sv
module fcfg_decide
    import fcfg_pkg::*;
(
    input  logic [2:0]  op,
    input  fn_entry_t   cur,
    input  logic [2:0]  new_state,
    input  logic [1:0]  flags,
    output fn_entry_t   nxt,
    output rsp_code_e   code,
    output logic        td_irq,
    output logic        td_xlat,
    output logic        unplug,
    output logic        evt,
    output logic        release_slot
);
    logic is_res, is_stby;

    assign is_res  = (cur.state == ST_RESERVED);
    assign is_stby = (cur.state == ST_STANDBY);

    always_comb begin
        nxt          = cur;
        code         = RC_NORMAL;
        td_irq       = 1'b0;
        td_xlat      = 1'b0;
        unplug       = 1'b0;
        evt          = 1'b0;
        release_slot = 1'b0;
        unique case (op)
            OP_CONFIG: begin
                if (is_res) begin
                    code = RC_RESERVED;
                end else if (is_stby) begin
                    nxt.state = ST_DISABLED;
                end else begin
                    code = RC_NO_ACTION;
                end
            end
            OP_DECONFIG: begin
                if (is_res) begin
                    code = RC_RESERVED;
                end else if (is_stby) begin
                    code = RC_NO_ACTION;
                end else begin
                    td_irq          = cur.irq_reg;
                    td_xlat         = cur.xlat_en;
                    nxt.irq_reg     = 1'b0;
                    nxt.xlat_en     = 1'b0;
                    nxt.fh_en       = 1'b0;
                    nxt.state       = ST_STANDBY;
                    if (cur.unplug_pend) begin
                        unplug       = 1'b1;
                        release_slot = 1'b1;
                        nxt.unplug_pend = 1'b0;
                    end
                end
            end
            OP_UNPLUG: begin
                if (is_res || is_stby) begin
                    unplug       = 1'b1;
                    release_slot = 1'b1;
                end else begin
                    nxt.unplug_pend = 1'b1;
                    evt             = 1'b1;
                end
            end
            OP_FNRESET: begin
                if (!is_res) begin
                    td_irq      = cur.irq_reg;
                    td_xlat     = cur.xlat_en;
                    nxt.irq_reg = 1'b0;
                    nxt.xlat_en = 1'b0;
                    if (!is_stby) begin
                        nxt.state = ST_DISABLED;
                        nxt.fh_en = 1'b0;
                    end
                end
            end
            OP_SETSTATE: begin
                nxt.state   = new_state;
                nxt.irq_reg = flags[0];
                nxt.xlat_en = flags[1];
                nxt.fh_en   = (new_state == ST_ENABLED);
            end
            OP_QUERY: begin
                code = RC_NORMAL;
            end
            default: begin
                code = RC_NO_ACTION;
            end
        endcase
    end
endmodule

// File: rtl/fcfg_ctrl.sv
module fcfg_ctrl
    import fcfg_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int FIDW  = 32,
    localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [FIDW-1:0] cmd_fid,
    input  logic [2:0]      cmd_state,
    input  logic [1:0]      cmd_flags,
    output logic            rsp_valid,
    output logic [3:0]      rsp_code,
    output logic [2:0]      rsp_state,
    output logic            rsp_fh_en,
    output logic [IDXW-1:0] rsp_slot,
    output logic            teardown_irq,
    output logic            teardown_xlat,
    output logic            unplug_fire,
    output logic            deconf_req_evt
);
    typedef struct packed {
        logic [NSLOT-1:0]             used;
        logic [NSLOT-1:0][FIDW-1:0]   ids;
        fn_entry_t [NSLOT-1:0]        ent;
        logic                         rsp_valid;
        rsp_code_e                    rsp_code;
        logic [2:0]                   rsp_state;
        logic                         rsp_fh_en;
        logic [IDXW-1:0]              rsp_slot;
        logic                         td_irq;
        logic                         td_xlat;
        logic                         unplug;
        logic                         evt;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NSLOT-1:0] match;
    logic             hit, free_any;
    logic [IDXW-1:0]  hit_idx, free_idx;

    fcfg_lookup #(.NSLOT(NSLOT), .FIDW(FIDW)) u_lookup (
        .key      (cmd_fid),
        .used     (regs_q.used),
        .ids      (regs_q.ids),
        .match    (match),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    fn_entry_t  cur_ent, nxt_ent;
    rsp_code_e  dec_code;
    logic       dec_td_irq, dec_td_xlat, dec_unplug, dec_evt, dec_release;

    assign cur_ent = regs_q.ent[hit_idx];

    fcfg_decide u_decide (
        .op           (cmd_op),
        .cur          (cur_ent),
        .new_state    (cmd_state),
        .flags        (cmd_flags),
        .nxt          (nxt_ent),
        .code         (dec_code),
        .td_irq       (dec_td_irq),
        .td_xlat      (dec_td_xlat),
        .unplug       (dec_unplug),
        .evt          (dec_evt),
        .release_slot (dec_release)
    );

    always_comb begin
        regs_d           = regs_q;
        regs_d.rsp_valid = cmd_valid;
        regs_d.rsp_code  = RC_NONE;
        regs_d.rsp_state = '0;
        regs_d.rsp_fh_en = 1'b0;
        regs_d.rsp_slot  = '0;
        regs_d.td_irq    = 1'b0;
        regs_d.td_xlat   = 1'b0;
        regs_d.unplug    = 1'b0;
        regs_d.evt       = 1'b0;
        if (cmd_valid) begin
            if (cmd_op == OP_ATTACH) begin
                if (hit) begin
                    regs_d.rsp_code = RC_IN_USE;
                    regs_d.rsp_slot = hit_idx;
                    regs_d.rsp_state = cur_ent.state;
                    regs_d.rsp_fh_en = cur_ent.fh_en;
                end else if (free_any) begin
                    regs_d.used[free_idx] = 1'b1;
                    regs_d.ids[free_idx]  = cmd_fid;
                    regs_d.ent[free_idx]  = '{state: cmd_state, default: 1'b0};
                    regs_d.rsp_code       = RC_NORMAL;
                    regs_d.rsp_slot       = free_idx;
                    regs_d.rsp_state      = cmd_state;
                end else begin
                    regs_d.rsp_code = RC_FULL;
                end
            end else if (!hit) begin
                regs_d.rsp_code = RC_UNKNOWN;
            end else begin
                regs_d.ent[hit_idx] = nxt_ent;
                if (dec_release) begin
                    regs_d.used[hit_idx] = 1'b0;
                end
                regs_d.rsp_code  = dec_code;
                regs_d.rsp_slot  = hit_idx;
                regs_d.rsp_state = nxt_ent.state;
                regs_d.rsp_fh_en = nxt_ent.fh_en;
                regs_d.td_irq    = dec_td_irq;
                regs_d.td_xlat   = dec_td_xlat;
                regs_d.unplug    = dec_unplug;
                regs_d.evt       = dec_evt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q          <= '0;
            regs_q.rsp_code <= RC_NONE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rsp_valid      = regs_q.rsp_valid;
    assign rsp_code       = regs_q.rsp_code;
    assign rsp_state      = regs_q.rsp_state;
    assign rsp_fh_en      = regs_q.rsp_fh_en;
    assign rsp_slot       = regs_q.rsp_slot;
    assign teardown_irq   = regs_q.td_irq;
    assign teardown_xlat  = regs_q.td_xlat;
    assign unplug_fire    = regs_q.unplug;
    assign deconf_req_evt = regs_q.evt;

    // R1: an unknown identifier or a full table leaves occupancy untouched
    a_r1_unknown_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code == RC_UNKNOWN || rsp_code == RC_FULL)) |-> $stable(regs_q.used));

    // R9: attach never leaves two slots holding the same identifier
    a_r9_unique_fid: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R11: responses and strobes only follow a command
    a_r11_rsp_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || teardown_irq || teardown_xlat || unplug_fire || deconf_req_evt)
            |-> $past(cmd_valid));

    // R5: teardown only accompanies a normal completion
    a_r5_teardown_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (teardown_irq || teardown_xlat) |-> (rsp_valid && rsp_code == RC_NORMAL));

    // R7: a deferred request and an immediate unplug never coincide
    a_r7_evt_excl: assert property (@(posedge clk) disable iff (!rst_n)
        deconf_req_evt |-> (!unplug_fire && rsp_code == RC_NORMAL));

    // R6: an unplug frees the addressed slot
    a_r6_unplug_frees: assert property (@(posedge clk) disable iff (!rst_n)
        unplug_fire |-> !regs_q.used[rsp_slot]);
endmodule

// File: tb/tb_fcfg_ctrl.sv
module tb_fcfg_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [31:0] cmd_fid;
    logic [2:0]  cmd_state;
    logic [1:0]  cmd_flags;
    logic        rsp_valid;
    logic [3:0]  rsp_code;
    logic [2:0]  rsp_state;
    logic        rsp_fh_en;
    logic [2:0]  rsp_slot;
    logic        teardown_irq, teardown_xlat, unplug_fire, deconf_req_evt;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcfg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_fid(cmd_fid), .cmd_state(cmd_state), .cmd_flags(cmd_flags),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_state(rsp_state),
        .rsp_fh_en(rsp_fh_en), .rsp_slot(rsp_slot), .teardown_irq(teardown_irq),
        .teardown_xlat(teardown_xlat), .unplug_fire(unplug_fire),
        .deconf_req_evt(deconf_req_evt)
    );

    localparam logic [2:0] ATT = 0, CFG = 1, DCF = 2, UNP = 3, FRS = 4, SET = 5, QRY = 6;
    localparam logic [2:0] S_RES = 0, S_STB = 1, S_DIS = 2, S_ENA = 3, S_BLK = 4, S_ERR = 5;
    localparam logic [3:0] C_OK = 1, C_NOP = 2, C_RES = 3, C_UNK = 4, C_FULL = 5, C_USE = 6;

    localparam logic [31:0] FA = 32'h1000_0001, FB = 32'h2000_0002, FC = 32'h3000_0003;
    localparam logic [31:0] FD = 32'h4000_0004, FE = 32'h5000_0005;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [31:0] fid,
                       input logic [2:0] st = 3'd0, input logic [1:0] fl = 2'd0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_fid = fid; cmd_state = st; cmd_flags = fl;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input int code, input int st,
                              input int ti, input int tx, input int up, input int ev);
        chk(req, "rsp_valid", int'(rsp_valid), 1);
        chk(req, "rsp_code", int'(rsp_code), code);
        if (st >= 0) chk(req, "rsp_state", int'(rsp_state), st);
        chk(req, "teardown_irq", int'(teardown_irq), ti);
        chk(req, "teardown_xlat", int'(teardown_xlat), tx);
        chk(req, "unplug_fire", int'(unplug_fire), up);
        chk(req, "deconf_req_evt", int'(deconf_req_evt), ev);
    endtask

    task automatic t_reset();
        chk("R11", "rsp_valid after reset", int'(rsp_valid), 0);
        chk("R11", "strobes after reset",
            int'({teardown_irq, teardown_xlat, unplug_fire, deconf_req_evt}), 0);
        @(negedge clk);
        chk("R11", "rsp_valid idle", int'(rsp_valid), 0);
    endtask

    task automatic t_attach();
        cmd(ATT, FA, S_RES); expect_rsp("R9", C_OK, S_RES, 0, 0, 0, 0);
        chk("R9", "slot A", int'(rsp_slot), 0);
        cmd(ATT, FB, S_STB); expect_rsp("R9", C_OK, S_STB, 0, 0, 0, 0);
        chk("R9", "slot B", int'(rsp_slot), 1);
        cmd(ATT, FA, S_STB); expect_rsp("R9", C_USE, -1, 0, 0, 0, 0);
        @(negedge clk);
        chk("R11", "single-cycle rsp", int'(rsp_valid), 0);
    endtask

    task automatic t_unknown();
        cmd(CFG, 32'hDEAD_BEEF); expect_rsp("R1", C_UNK, -1, 0, 0, 0, 0);
        cmd(QRY, FA); expect_rsp("R1", C_OK, S_RES, 0, 0, 0, 0);
        cmd(QRY, FB); expect_rsp("R1", C_OK, S_STB, 0, 0, 0, 0);
    endtask

    task automatic t_config();
        cmd(CFG, FA); expect_rsp("R2", C_RES, S_RES, 0, 0, 0, 0);
        cmd(QRY, FA); expect_rsp("R2", C_OK, S_RES, 0, 0, 0, 0);
        cmd(CFG, FB); expect_rsp("R3", C_OK, S_DIS, 0, 0, 0, 0);
        cmd(CFG, FB); expect_rsp("R3", C_NOP, S_DIS, 0, 0, 0, 0);
    endtask

    task automatic t_deconfig();
        cmd(DCF, FA); expect_rsp("R4", C_RES, S_RES, 0, 0, 0, 0);
        cmd(ATT, FC, S_STB); expect_rsp("R9", C_OK, S_STB, 0, 0, 0, 0);
        chk("R9", "slot C", int'(rsp_slot), 2);
        cmd(DCF, FC); expect_rsp("R4", C_NOP, S_STB, 0, 0, 0, 0);
        cmd(SET, FB, S_ENA, 2'b01); expect_rsp("R10", C_OK, S_ENA, 0, 0, 0, 0);
        chk("R10", "fh_en enabled", int'(rsp_fh_en), 1);
        cmd(DCF, FB); expect_rsp("R5", C_OK, S_STB, 1, 0, 0, 0);
        chk("R5", "fh_en cleared", int'(rsp_fh_en), 0);
        cmd(SET, FB, S_BLK, 2'b10); expect_rsp("R10", C_OK, S_BLK, 0, 0, 0, 0);
        chk("R10", "fh_en blocked", int'(rsp_fh_en), 0);
        cmd(DCF, FB); expect_rsp("R5", C_OK, S_STB, 0, 1, 0, 0);
        cmd(CFG, FB); cmd(SET, FB, S_ERR, 2'b00);
        cmd(DCF, FB); expect_rsp("R5", C_OK, S_STB, 0, 0, 0, 0);
    endtask

    task automatic t_unplug();
        cmd(UNP, FB); expect_rsp("R7", C_OK, S_STB, 0, 0, 1, 0);
        cmd(QRY, FB); expect_rsp("R7", C_UNK, -1, 0, 0, 0, 0);
        cmd(ATT, FD, S_STB); expect_rsp("R9", C_OK, S_STB, 0, 0, 0, 0);
        chk("R9", "lowest free slot reused", int'(rsp_slot), 1);
        cmd(SET, FD, S_ENA, 2'b11);
        cmd(UNP, FD); expect_rsp("R7", C_OK, S_ENA, 0, 0, 0, 1);
        cmd(UNP, FD); expect_rsp("R7", C_OK, S_ENA, 0, 0, 0, 1);
        cmd(QRY, FD); expect_rsp("R7", C_OK, S_ENA, 0, 0, 0, 0);
        cmd(DCF, FD); expect_rsp("R6", C_OK, S_STB, 1, 1, 1, 0);
        cmd(QRY, FD); expect_rsp("R6", C_UNK, -1, 0, 0, 0, 0);
        cmd(UNP, FA); expect_rsp("R7", C_OK, S_RES, 0, 0, 1, 0);
        cmd(ATT, FA, S_RES); expect_rsp("R9", C_OK, S_RES, 0, 0, 0, 0);
        chk("R9", "slot A again", int'(rsp_slot), 0);
    endtask

    task automatic t_fnreset();
        cmd(FRS, FA); expect_rsp("R8", C_OK, S_RES, 0, 0, 0, 0);
        cmd(SET, FC, S_STB, 2'b01);
        cmd(FRS, FC); expect_rsp("R8", C_OK, S_STB, 1, 0, 0, 0);
        cmd(ATT, FE, S_STB); expect_rsp("R9", C_OK, S_STB, 0, 0, 0, 0);
        cmd(SET, FE, S_ENA, 2'b10); chk("R10", "fh_en", int'(rsp_fh_en), 1);
        cmd(FRS, FE); expect_rsp("R8", C_OK, S_DIS, 0, 1, 0, 0);
        chk("R8", "fh_en cleared", int'(rsp_fh_en), 0);
        cmd(QRY, FE); expect_rsp("R10", C_OK, S_DIS, 0, 0, 0, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 5; i++) begin
            cmd(ATT, 32'h9000_0000 + 32'(i), S_RES);
            chk("R9", "fill code", int'(rsp_code), C_OK);
        end
        cmd(ATT, 32'hA000_0000, S_RES); expect_rsp("R9", C_FULL, -1, 0, 0, 0, 0);
        cmd(QRY, 32'hA000_0000); expect_rsp("R1", C_UNK, -1, 0, 0, 0, 0);
        cmd(QRY, FE); expect_rsp("R1", C_OK, S_DIS, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_fid = '0;
        cmd_state = '0; cmd_flags = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_attach();
        t_unknown();
        t_config();
        t_deconfig();
        t_unplug();
        t_fnreset();
        t_full();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule